// File: doc/BRIEF.md
# Ripple Add/Subtract Unit

A purely combinational N-bit two's-complement adder/subtractor. It is built as a chain of one-bit full-adder cells. Each cell splits its operand pair into three carry-status terms: generate (both bits one), delete (both bits zero) and the XOR propagate term. The cell then forms its carry-out as generate OR (propagate AND carry-in), and reuses the same XOR term for its sum bit. The carry travels from bit 0 up to the top bit, one cell after another.

A subtract control turns the unit into A minus B. It does this by inverting every B bit in front of its cell and forcing the carry into bit 0 high. In add mode an external carry-in feeds bit 0, which lets wider sums be chained. The unit reports the N-bit result, the carry out of the top cell, a signed overflow flag and the result sign. It also exports the three per-bit carry-status vectors, so that neighbouring logic can inspect how each bit position behaved.

Top module: `ripple_addsub`

## Requirements
- R1: With sub_i=0, {cout_o, sum_o} equals A + B + cin_i as an unsigned (N+1)-bit value.
- R2: With sub_i=1, sum_o equals (A - B) mod 2^N, and cout_o equals the carry out of A + ~B + 1. That carry is 1 exactly when A >= B unsigned.
- R3: With sub_i=1, cin_i has no effect on any output.
- R4: ovf_o is 1 exactly when the carry into the top bit differs from the carry out of it. This happens when the signed result does not fit in N bits.
- R5: sign_o equals sum_o[N-1].
- R6: gen_o[i] = A[i] AND E[i]. E is the effective second operand: B when sub_i=0, ~B when sub_i=1.
- R7: del_o[i] = NOT A[i] AND NOT E[i].
- R8: prop_o[i] = A[i] XOR E[i].
- R9: For every bit i and every input, exactly one of gen_o[i], prop_o[i] and del_o[i] is 1.
- R10: For N=8, in add mode with cin_i=0, A=8'h01 and B=8'h7F carry through every stage. Bit 0 generates, bits 1 to 6 propagate and bit 7 deletes. The result is sum_o=8'h80, cout_o=0, ovf_o=1 and sign_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sub_i | input | 1 | 1 selects A minus B, 0 selects A plus B |
| cin_i | input | 1 | Carry into bit 0 in add mode |
| sum_o | output | N | Result |
| cout_o | output | 1 | Carry out of the top cell |
| ovf_o | output | 1 | Signed overflow |
| sign_o | output | 1 | Sign of the result |
| gen_o | output | N | Per-bit generate status |
| prop_o | output | N | Per-bit XOR propagate status |
| del_o | output | N | Per-bit delete status |

## Verification
The bench drives the full-length carry pattern. A chain that loses the carry partway up shows a wrong upper sum bit, and wrong overflow and sign values. In subtract mode it toggles the external carry-in. A unit that lets that carry-in leak through gives a result off by one. It also drives operands at the signed limits, where an overflow flag taken from the wrong carry pair fires on safe sums or misses real wraps. The status vectors are compared against the effective operand, so status taken from the raw B instead of the inverted B is exposed in subtract mode.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Carry status of one bit position; exactly one field is set.
    typedef struct packed {
        logic gen;
        logic prop;
        logic del;
    } carry_stat_t;

    // Everything one cell produces.
    typedef struct packed {
        logic        sum;
        logic        co;
        carry_stat_t stat;
    } cell_out_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import addsub_pkg::*;
(
    input  logic        a_i,
    input  logic        b_i,
    input  logic        ci_i,
    output logic        sum_o,
    output logic        co_o,
    output carry_stat_t stat_o
);

    cell_out_t cell_d;

    always_comb begin
        cell_d           = '0;
        cell_d.stat.gen  = a_i & b_i;
        cell_d.stat.del  = ~a_i & ~b_i;
        cell_d.stat.prop = a_i ^ b_i;
        // Carry from G and P'; P' is shared with the sum.
        cell_d.co        = cell_d.stat.gen | (cell_d.stat.prop & ci_i);
        cell_d.sum       = cell_d.stat.prop ^ ci_i;
    end

    assign sum_o  = cell_d.sum;
    assign co_o   = cell_d.co;
    assign stat_o = cell_d.stat;

endmodule

// File: rtl/operand_prep.sv
module operand_prep #(
    parameter int N = 8
) (
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [N-1:0] b_eff_o,
    output logic         c0_o
);

    for (genvar i = 0; i < N; i++) begin : g_inv
        assign b_eff_o[i] = b_i[i] ^ sub_i;
    end

    // Subtraction forces the +1 of the two's complement; cin is dropped.
    assign c0_o = sub_i ? 1'b1 : cin_i;

endmodule

// File: rtl/carry_chain.sv
module carry_chain
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic          [N-1:0] a_i,
    input  logic          [N-1:0] b_i,
    input  logic                  c0_i,
    output logic          [N-1:0] sum_o,
    output logic          [N:0]   carry_o,
    output carry_stat_t   [N-1:0] stat_o
);

    logic [N:0] c_d;

    assign c_d[0] = c0_i;

    for (genvar i = 0; i < N; i++) begin : g_cell
        fa_cell u_cell (
            .a_i   (a_i[i]),
            .b_i   (b_i[i]),
            .ci_i  (c_d[i]),
            .sum_o (sum_o[i]),
            .co_o  (c_d[i+1]),
            .stat_o(stat_o[i])
        );
    end

    assign carry_o = c_d;

endmodule

// File: rtl/flag_unit.sv
module flag_unit #(
    parameter int N = 8
) (
    input  logic [N-1:0] sum_i,
    input  logic [N:0]   carry_i,
    output logic         cout_o,
    output logic         ovf_o,
    output logic         sign_o
);

    localparam int MSB = N - 1;

    assign cout_o = carry_i[N];
    assign ovf_o  = carry_i[N] ^ carry_i[MSB];
    assign sign_o = sum_i[MSB];

endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub
    import addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o,
    output logic         sign_o,
    output logic [N-1:0] gen_o,
    output logic [N-1:0] prop_o,
    output logic [N-1:0] del_o
);

    localparam int MSB = N - 1;

    logic        [N-1:0] b_eff_d;
    logic                c0_d;
    logic        [N:0]   carry_d;
    carry_stat_t [N-1:0] stat_d;

    operand_prep #(.N(N)) u_prep (
        .b_i    (b_i),
        .sub_i  (sub_i),
        .cin_i  (cin_i),
        .b_eff_o(b_eff_d),
        .c0_o   (c0_d)
    );

    carry_chain #(.N(N)) u_chain (
        .a_i    (a_i),
        .b_i    (b_eff_d),
        .c0_i   (c0_d),
        .sum_o  (sum_o),
        .carry_o(carry_d),
        .stat_o (stat_d)
    );

    flag_unit #(.N(N)) u_flags (
        .sum_i  (sum_o),
        .carry_i(carry_d),
        .cout_o (cout_o),
        .ovf_o  (ovf_o),
        .sign_o (sign_o)
    );

    for (genvar i = 0; i < N; i++) begin : g_stat
        assign gen_o[i]  = stat_d[i].gen;
        assign prop_o[i] = stat_d[i].prop;
        assign del_o[i]  = stat_d[i].del;
    end

    // Behavioural cross-checks against the ports.
    logic [N:0] ref_add_d;
    logic [N:0] ref_sub_d;

    always_comb begin
        ref_add_d = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
        ref_sub_d = {1'b0, a_i} + {1'b0, ~b_i} + {{N{1'b0}}, 1'b1};
        if (!sub_i) begin
            assert_add_result_R1: assert ({cout_o, sum_o} == ref_add_d);
        end else begin
            // R3: result matches A - B whatever cin_i is.
            assert_sub_result_R2: assert ({cout_o, sum_o} == ref_sub_d);
        end
        assert_signed_overflow_R4: assert (ovf_o ==
            ((a_i[MSB] == b_eff_d[MSB]) && (sum_o[MSB] != a_i[MSB])));
        for (int i = 0; i < N; i++) begin
            assert_status_onehot_R9: assert ($countones({gen_o[i], prop_o[i], del_o[i]}) == 1);
        end
    end

endmodule

// File: tb/sim_ripple_addsub.sv
`timescale 1ns/1ps
module sim_ripple_addsub;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [N-1:0] a, b, sum, gen, prop, del;
    logic         sub, cin, cout, ovf, sign;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    ripple_addsub #(.N(N)) u0 (
        .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .ovf_o(ovf), .sign_o(sign),
        .gen_o(gen), .prop_o(prop), .del_o(del)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] av, input logic [N-1:0] bv,
                         input logic sv, input logic cv);
        @(negedge clk);
        a = av; b = bv; sub = sv; cin = cv;
        #2;
    endtask

    // Full comparison against a reference computed from the requirements.
    task automatic check_all(input string tag);
        logic [N-1:0] e;
        logic         c0;
        logic [N:0]   full;
        logic         eovf;
        e    = sub ? ~b : b;
        c0   = sub ? 1'b1 : cin;
        full = {1'b0, a} + {1'b0, e} + {{N{1'b0}}, c0};
        eovf = (a[N-1] == e[N-1]) && (full[N-1] != a[N-1]);
        if (!sub) check({cout, sum} == full, {tag, " R1"}, {cout, sum}, full);
        else      check({cout, sum} == full, {tag, " R2"}, {cout, sum}, full);
        check(ovf == eovf, {tag, " R4"}, ovf, eovf);
        check(sign == full[N-1], {tag, " R5"}, sign, full[N-1]);
        check(gen == (a & e), {tag, " R6"}, gen, a & e);
        check(del == (~a & ~e), {tag, " R7"}, del, ~a & ~e);
        check(prop == (a ^ e), {tag, " R8"}, prop, a ^ e);
        check(((gen ^ prop ^ del) == '1) && ((gen & prop) == '0) &&
              ((gen & del) == '0) && ((prop & del) == '0),
              {tag, " R9"}, {gen, prop, del}, 0);
    endtask

    task automatic t_reset_state;
        drive('0, '0, 1'b0, 1'b0);
        check(sum == '0 && cout == 1'b0, "reset R1", {cout, sum}, 0);
        check(del == '1, "reset R7", del, 8'hFF);
        check_all("reset");
    endtask

    task automatic t_ripple_r10;
        drive(8'h01, 8'h7F, 1'b0, 1'b0);
        check(sum == 8'h80, "ripple R10 sum", sum, 8'h80);
        check(cout == 1'b0 && ovf == 1'b1 && sign == 1'b1, "ripple R10 flags",
              {cout, ovf, sign}, 3'b011);
        check(gen == 8'h01 && prop == 8'h7E && del == 8'h80, "ripple R10 status",
              {gen, prop, del}, {8'h01, 8'h7E, 8'h80});
        check_all("ripple");
    endtask

    task automatic t_add_corners;
        drive(8'hFF, 8'h01, 1'b0, 1'b0); check_all("wrap");
        check(cout == 1'b1 && sum == 8'h00, "wrap R1", {cout, sum}, 9'h100);
        drive(8'hFF, 8'hFF, 1'b0, 1'b1); check_all("allones");
        check({cout, sum} == 9'h1FF, "allones cin R1", {cout, sum}, 9'h1FF);
        drive(8'h7F, 8'h00, 1'b0, 1'b1); check_all("cin ovf");
        check(ovf == 1'b1, "cin ovf R4", ovf, 1);
        drive(8'h80, 8'h80, 1'b0, 1'b0); check_all("negneg");
        check(ovf == 1'b1 && cout == 1'b1, "negneg R4", {ovf, cout}, 2'b11);
        drive(8'h40, 8'hC0, 1'b0, 1'b0); check_all("mixed");
        check(ovf == 1'b0, "mixed R4", ovf, 0);
    endtask

    task automatic t_subtract;
        drive(8'h05, 8'h03, 1'b1, 1'b0); check_all("sub");
        check(sum == 8'h02 && cout == 1'b1, "sub R2", {cout, sum}, 9'h102);
        drive(8'h03, 8'h05, 1'b1, 1'b0); check_all("subneg");
        check(sum == 8'hFE && cout == 1'b0 && sign == 1'b1, "subneg R2",
              {cout, sum}, 9'h0FE);
        drive(8'h80, 8'h01, 1'b1, 1'b0); check_all("subovf");
        check(ovf == 1'b1 && sum == 8'h7F, "subovf R4", {ovf, sum}, 9'h17F);
        drive(8'h00, 8'h00, 1'b1, 1'b0); check_all("subzero");
        check({cout, sum} == 9'h100, "subzero R2", {cout, sum}, 9'h100);
    endtask

    task automatic t_cin_ignored;
        logic [N-1:0] s0, g0;
        logic [2:0]   f0;
        drive(8'h5A, 8'h3C, 1'b1, 1'b0);
        s0 = sum; g0 = gen; f0 = {cout, ovf, sign};
        drive(8'h5A, 8'h3C, 1'b1, 1'b1);
        check(sum == s0, "cin ignored R3 sum", sum, s0);
        check(sum == 8'h1E, "cin ignored R3 value", sum, 8'h1E);
        check({cout, ovf, sign} == f0 && gen == g0, "cin ignored R3 flags",
              {cout, ovf, sign}, f0);
        check_all("subcin");
    endtask

    task automatic t_random;
        for (int k = 0; k < 300; k++) begin
            drive($urandom, $urandom, $urandom_range(1, 0), $urandom_range(1, 0));
            check_all("random");
        end
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ripple_r10();
        t_add_corners();
        t_subtract();
        t_cin_ignored();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule